// File: doc/BRIEF.md
# Programmable Tone and Ring Generator

This block is a digital tone source for a ring, alert or call-progress path. Once per sample frame (an 8 kHz strobe from the surrounding audio pipeline) it produces one signed 14-bit sample together with a one-cycle valid pulse. The sample is either a sine or a square wave. In dual mode it is the sum of two independently tuned tones, which is how touch-tone (DTMF) pairs are formed.

Pitch is set by an 8-bit frequency code per tone. A 2-bit range select multiplies the code by 1, 2 or 4, which gives step sizes of about 3.9 Hz, 7.8 Hz or 15.6 Hz. The top of each range is about 996 Hz, 1992 Hz or 3984 Hz. A 4-bit level code attenuates the result in 3 dB steps over 27 dB. Each tone keeps its own 11-bit phase accumulator, and one full wave cycle is 2048 counts.

Top module: `tone_ring_gen`

## Requirements
- R1: While reset is held and right after it is released, `sample_o` is 0, `valid_o` is 0 and both tone phases are 0.
- R2: `valid_o` is 1 in exactly the cycle after a cycle with `tick_i` high. `sample_o` changes only in that cycle and holds its value otherwise.
- R3: In sine mode with a single tone, the k-th sample after reset (k = 0, 1, ...) equals 8191·sin(2π·P/2048) within ±24, where P = (k·inc) mod 2048 and inc is the tone's phase increment.
- R4: The phase increment is the frequency code shifted left by 0, 1 or 2 bits for range select 0, 1 or 2. Range select 3 behaves as 2. The phase advances only on a tick.
- R5: In square mode, a tone is +8191 while phase bit 10 is 0 and −8191 while it is 1.
- R6: A tone whose frequency code is 0 contributes 0. In single mode the output is then exactly 0 in both wave modes.
- R7: With `dual_i` = 1, the pre-attenuation sample is (tone A + tone B)/2, rounded toward negative infinity. Tone A uses `freq_a_i` and tone B uses `freq_b_i`, and both follow the same range and wave mode.
- R8: Level code a, with a from 0 to 9, scales the sample by 0.7071^a (3 dB per step), within ±24 of the ideal value.
- R9: Level codes 10 to 15 give the same result as code 9.
- R10: `sample_o` never equals −8192, so the output range is symmetric.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle sample-frame strobe (8 kHz) |
| freq_a_i | input | 8 | Frequency code of tone A |
| freq_b_i | input | 8 | Frequency code of tone B (used in dual mode) |
| range_i | input | 2 | Step-size select: 0 fine, 1 middle, 2 or 3 coarse |
| square_i | input | 1 | 1 selects square wave, 0 selects sine |
| dual_i | input | 1 | 1 sums tones A and B at half scale each |
| level_i | input | 4 | Attenuation in 3 dB steps, 0 to 9 (10 to 15 act as 9) |
| sample_o | output | 14 | Signed output sample |
| valid_o | output | 1 | High for one cycle when a new sample is presented |

## Verification
The bench runs the sine shape at a very slow code, a mid code and a code just under the Nyquist limit. Together these expose curve errors near the peaks, near the zero crossings and under phase wrap. The same code is repeated across all four range settings, so a wrong shift amount or a mis-decoded range 3 shows up as a phase drift. Square runs, dual-tone runs in both wave shapes and a zero-code tone separate the shaping path from the mixing path. A full sweep of all sixteen level codes separates the step constant from the clamp above code 9.

// File: rtl/tone_pkg.sv
`timescale 1ns/1ps
package tone_pkg;
    localparam int PHASE_W   = 11;
    localparam int FREQ_W    = 8;
    localparam int SAMPLE_W  = 14;
    localparam int LEVEL_W   = 4;
    localparam int LEVEL_MAX = 9;

    typedef enum logic [1:0] {
        RNG_FINE   = 2'd0,
        RNG_MID    = 2'd1,
        RNG_COARSE = 2'd2,
        RNG_ALIAS  = 2'd3
    } range_e;
endpackage

// File: rtl/tone_phase_acc.sv
`timescale 1ns/1ps
module tone_phase_acc
    import tone_pkg::*;
#(
    parameter int PHASE_BITS = PHASE_W,
    parameter int FREQ_BITS  = FREQ_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_i,
    input  logic [FREQ_BITS-1:0]  freq_i,
    input  logic [1:0]            range_i,
    output logic [PHASE_BITS-1:0] phase_o
);
    typedef struct packed {
        logic [PHASE_BITS-1:0] phase;
    } acc_t;

    acc_t acc_d, acc_q;
    logic [PHASE_BITS-1:0] step;

    always_comb begin
        step = PHASE_BITS'(freq_i);
        case (range_e'(range_i))
            RNG_FINE: step = step;
            RNG_MID:  step = step << 1;
            default:  step = step << 2;
        endcase
        acc_d = acc_q;
        if (tick_i) begin
            acc_d.phase = acc_q.phase + step;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign phase_o = acc_q.phase;

    // R4
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(phase_o));
endmodule

// File: rtl/tone_shape.sv
`timescale 1ns/1ps
module tone_shape
    import tone_pkg::*;
#(
    parameter int PHASE_BITS  = PHASE_W,
    parameter int SAMPLE_BITS = SAMPLE_W
) (
    input  logic [PHASE_BITS-1:0]  phase_i,
    input  logic                   square_i,
    input  logic                   mute_i,
    output logic [SAMPLE_BITS-1:0] sample_o
);
    localparam int          HALF = 2 ** (PHASE_BITS - 1);
    localparam int          QB   = 15;
    localparam int          YSH  = 2 * (PHASE_BITS - 1) - (QB + 2);
    localparam logic [63:0] FS   = 64'(2 ** (SAMPLE_BITS - 1) - 1);
    localparam logic [63:0] CA   = 64'd25395;
    localparam logic [63:0] CB   = 64'd7373;

    logic [63:0] h_pos, par, y_q, corr, s_q, mag, mag_c;
    logic        neg_half;

    always_comb begin
        neg_half = phase_i[PHASE_BITS-1];
        h_pos    = 64'(phase_i[PHASE_BITS-2:0]);
        par      = h_pos * (64'(HALF) - h_pos);
        y_q      = par >> YSH;
        corr     = CA + ((CB * y_q) >> QB);
        s_q      = (y_q * corr) >> QB;
        mag      = (s_q * FS) >> QB;
        mag_c    = (mag > FS) ? FS : mag;
        if (mute_i) begin
            sample_o = '0;
        end else if (square_i) begin
            sample_o = neg_half ? -SAMPLE_BITS'(FS) : SAMPLE_BITS'(FS);
        end else begin
            sample_o = neg_half ? -SAMPLE_BITS'(mag_c) : SAMPLE_BITS'(mag_c);
        end
    end
endmodule

// File: rtl/tone_level.sv
`timescale 1ns/1ps
module tone_level
    import tone_pkg::*;
#(
    parameter int SAMPLE_BITS = SAMPLE_W,
    parameter int LEVEL_BITS  = LEVEL_W
) (
    input  logic [SAMPLE_BITS-1:0] sample_i,
    input  logic [LEVEL_BITS-1:0]  level_i,
    output logic [SAMPLE_BITS-1:0] sample_o
);
    localparam int       WW     = SAMPLE_BITS + 2;
    localparam int       KB     = 8;
    localparam logic [KB-1:0] ROOT_HALF = 8'b1011_0101;

    logic [LEVEL_BITS-1:0] lvl;
    logic signed [WW-1:0]  wide_in, base, acc;

    always_comb begin
        lvl     = (level_i > LEVEL_BITS'(LEVEL_MAX)) ? LEVEL_BITS'(LEVEL_MAX) : level_i;
        wide_in = WW'($signed(sample_i));
        base    = wide_in >>> lvl[LEVEL_BITS-1:1];
        if (lvl[0]) begin
            acc = '0;
            for (int i = 0; i < KB; i++) begin
                if (ROOT_HALF[KB-1-i]) begin
                    acc = acc + (base >>> (i + 1));
                end
            end
        end else begin
            acc = base;
        end
        sample_o = acc[SAMPLE_BITS-1:0];
    end
endmodule

// File: rtl/tone_ring_gen.sv
`timescale 1ns/1ps
module tone_ring_gen
    import tone_pkg::*;
#(
    parameter int PHASE_BITS  = PHASE_W,
    parameter int FREQ_BITS   = FREQ_W,
    parameter int SAMPLE_BITS = SAMPLE_W,
    parameter int LEVEL_BITS  = LEVEL_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick_i,
    input  logic [FREQ_BITS-1:0]   freq_a_i,
    input  logic [FREQ_BITS-1:0]   freq_b_i,
    input  logic [1:0]             range_i,
    input  logic                   square_i,
    input  logic                   dual_i,
    input  logic [LEVEL_BITS-1:0]  level_i,
    output logic [SAMPLE_BITS-1:0] sample_o,
    output logic                   valid_o
);
    localparam int NTONES = 2;
    localparam int MW     = SAMPLE_BITS + 1;
    localparam logic signed [SAMPLE_BITS-1:0] FS_POS = SAMPLE_BITS'(2 ** (SAMPLE_BITS - 1) - 1);
    localparam logic signed [SAMPLE_BITS-1:0] MOST_NEG = {1'b1, {(SAMPLE_BITS-1){1'b0}}};

    typedef struct packed {
        logic [SAMPLE_BITS-1:0] sample;
        logic                   valid;
    } out_t;

    logic [FREQ_BITS-1:0]   freq_arr  [NTONES];
    logic [PHASE_BITS-1:0]  phase_arr [NTONES];
    logic [SAMPLE_BITS-1:0] tone_arr  [NTONES];
    logic signed [MW-1:0]   mix_sum;
    logic [SAMPLE_BITS-1:0] mixed, leveled;
    out_t out_d, out_q;

    assign freq_arr[0] = freq_a_i;
    assign freq_arr[1] = freq_b_i;

    for (genvar t = 0; t < NTONES; t++) begin : g_tone
        tone_phase_acc #(
            .PHASE_BITS (PHASE_BITS),
            .FREQ_BITS  (FREQ_BITS)
        ) u_acc (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (tick_i),
            .freq_i  (freq_arr[t]),
            .range_i (range_i),
            .phase_o (phase_arr[t])
        );

        tone_shape #(
            .PHASE_BITS  (PHASE_BITS),
            .SAMPLE_BITS (SAMPLE_BITS)
        ) u_shape (
            .phase_i  (phase_arr[t]),
            .square_i (square_i),
            .mute_i   (freq_arr[t] == '0),
            .sample_o (tone_arr[t])
        );
    end

    always_comb begin
        mix_sum = MW'($signed(tone_arr[0])) + MW'($signed(tone_arr[1]));
        mixed   = dual_i ? mix_sum[MW-1:1] : tone_arr[0];
    end

    tone_level #(
        .SAMPLE_BITS (SAMPLE_BITS),
        .LEVEL_BITS  (LEVEL_BITS)
    ) u_level (
        .sample_i (mixed),
        .level_i  (level_i),
        .sample_o (leveled)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = tick_i;
        if (tick_i) begin
            out_d.sample = leveled;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign sample_o = out_q.sample;
    assign valid_o  = out_q.valid;

    // R2
    valid_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(tick_i));

    // R2
    sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(sample_o));

    // R6
    mute_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !dual_i && freq_a_i == '0) |=> (sample_o == '0));

    // R5
    square_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && square_i && !dual_i && level_i == '0 && freq_a_i != '0)
        |=> ($signed(sample_o) == FS_POS || $signed(sample_o) == -FS_POS));

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (sample_o != MOST_NEG));
endmodule

// File: tb/tb_tone_ring_gen.sv
`timescale 1ns/1ps
module tb_tone_ring_gen;
    logic       clk = 1'b0;
    logic       rst_n, tick;
    logic [7:0] fa, fb;
    logic [1:0] rng;
    logic       sq, dual;
    logic [3:0] lvl;
    logic [13:0] smp;
    logic        vld;

    int checks = 0;
    int errors = 0;
    int pa = 0;
    int pb = 0;

    always #10 clk = ~clk;

    tone_ring_gen dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .freq_a_i (fa),
        .freq_b_i (fb),
        .range_i  (rng),
        .square_i (sq),
        .dual_i   (dual),
        .level_i  (lvl),
        .sample_o (smp),
        .valid_o  (vld)
    );

    task automatic check_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_near(input string req, input int act, input real exp, input real tol);
        real d;
        checks++;
        d = act - exp;
        if (d < 0.0) d = -d;
        if (d > tol) begin
            errors++;
            $display("FAIL %s actual %0d expected %0f", req, act, exp);
        end
    endtask

    function automatic real tone_ideal(input int code, input int ph, input logic square);
        if (code == 0) return 0.0;
        if (square) return (ph < 1024) ? 8191.0 : -8191.0;
        return 8191.0 * $sin(2.0 * 3.14159265358979 * ph / 2048.0);
    endfunction

    function automatic real gain_of(input int a);
        real g = 1.0;
        int  n = (a > 9) ? 9 : a;
        for (int i = 0; i < n; i++) g = g * 0.70710678;
        return g;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        tick  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        pa = 0;
        pb = 0;
        @(negedge clk);
    endtask

    task automatic run_seq(input string req, input int n, input real tol);
        int  sh, inca, incb, hold;
        real ta, tb, ex;
        sh   = (rng == 2'd0) ? 0 : (rng == 2'd1) ? 1 : 2;
        inca = int'(fa) << sh;
        incb = int'(fb) << sh;
        for (int k = 0; k < n; k++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            ta = tone_ideal(int'(fa), pa, sq);
            tb = tone_ideal(int'(fb), pb, sq);
            ex = dual ? (ta + tb) / 2.0 : ta;
            ex = ex * gain_of(int'(lvl));
            check_near(req, int'($signed(smp)), ex, tol);
            check_int("R2 valid after tick", int'(vld), 1);
            check_int("R10 no most-negative code", int'(smp == 14'h2000), 0);
            hold = int'($signed(smp));
            pa = (pa + inca) % 2048;
            pb = (pb + incb) % 2048;
            @(negedge clk);
            check_int("R2 valid low between ticks", int'(vld), 0);
            check_int("R2 sample held between ticks", int'($signed(smp)), hold);
        end
    endtask

    task automatic setup(input int a, input int b, input int r, input logic s,
                         input logic d, input int l);
        fa = 8'(a); fb = 8'(b); rng = 2'(r); sq = s; dual = d; lvl = 4'(l);
        do_reset();
    endtask

    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        fa = 0; fb = 0; rng = 0; sq = 0; dual = 0; lvl = 0;
        rst_n = 1'b0; tick = 1'b0;
        repeat (2) @(negedge clk);
        // R1: reset state
        check_int("R1 sample at reset", int'(smp), 0);
        check_int("R1 valid at reset", int'(vld), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_int("R1 sample after release", int'(smp), 0);

        // R3: sine, single tone, slow / mid / near Nyquist
        setup(64, 0, 0, 1'b0, 1'b0, 0);  run_seq("R3 sine code 64", 40, 24.0);
        setup(5, 0, 0, 1'b0, 1'b0, 0);   run_seq("R3 sine code 5", 30, 24.0);
        setup(255, 0, 2, 1'b0, 1'b0, 0); run_seq("R3 sine code 255 coarse", 24, 24.0);
        setup(1, 0, 0, 1'b0, 1'b0, 0);   run_seq("R3 sine code 1", 8, 24.0);

        // R4: range select shifts; range 3 as range 2
        for (int r = 0; r < 4; r++) begin
            setup(37, 0, r, 1'b0, 1'b0, 0);
            run_seq("R4 range step", 24, 24.0);
        end

        // R5: square shape
        setup(100, 0, 0, 1'b1, 1'b0, 0); run_seq("R5 square code 100", 30, 0.5);
        setup(13, 0, 1, 1'b1, 1'b0, 0);  run_seq("R5 square code 13 mid", 40, 0.5);

        // R6: zero code gives silence
        setup(0, 0, 0, 1'b0, 1'b0, 0);   run_seq("R6 zero code sine", 6, 0.0);
        setup(0, 0, 2, 1'b1, 1'b0, 0);   run_seq("R6 zero code square", 6, 0.0);
        setup(80, 0, 0, 1'b0, 1'b1, 0);  run_seq("R6 dual with silent tone B", 20, 24.0);

        // R7: dual-tone sums
        setup(177, 97, 0, 1'b0, 1'b1, 0); run_seq("R7 dual sine", 40, 24.0);
        setup(60, 23, 1, 1'b1, 1'b1, 0);  run_seq("R7 dual square", 40, 0.5);

        // R8 and R9: full level sweep
        for (int l = 0; l < 16; l++) begin
            setup(64, 0, 0, 1'b1, 1'b0, l);
            run_seq((l > 9) ? "R9 level clamp square" : "R8 level step square", 4, 24.0);
            setup(64, 0, 0, 1'b0, 1'b0, l);
            run_seq((l > 9) ? "R9 level clamp sine" : "R8 level step sine", 16, 24.0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule